// File: doc/BRIEF.md
# Fractional Pixel Clock Generator

This block derives a pixel clock from a fast source clock in two counter stages, and it runs entirely in the source clock domain. The first stage divides by a mixed number: an integer part plus a fraction num/den. A phase accumulator decides which periods get one extra source cycle, so that over many periods the mean period equals the integer part plus num/den. Each period of this stage shows up as a one-cycle tick. The second stage counts those ticks to make the pixel clock waveform.

The pixel clock output is registered. While no transfer is running it rests at a programmable idle level. A one-cycle strobe marks the pixel clock edge on which data is launched, either the rising edge or the falling edge, chosen by a select input. Both stages take in new settings only at their own period boundaries, so changing a setting never produces a shortened pulse. A gating enable freezes the whole block in place.

Top module: `pixclk_frac_gen`

## Requirements
- R1: With integer field value N, denominator den and numerator num where 0 < num < den, every divider period lasts either N or N+1 source cycles. K consecutive periods counted from reset last exactly K*N + floor(K*num/den) source cycles in total.
- R2: An integer field of 0 divides by 2^N_W, which is 256 at the default width. A field of 1 is treated as 2. Every other field value is used as it is.
- R3: When den is 0 or num is 0, every divider period lasts exactly N source cycles.
- R4: Each pixel clock period lasts M divider ticks, where M = post_div + 1. A post_div field of 0 is treated as 1, which gives M = 2. At the default width M therefore runs from 2 to 64.
- R5: Within each pixel period, pix_clk is high for floor(M/2) ticks and low for the rest. After reset the first rise of pix_clk comes 2 source cycles after the first div_tick.
- R6: When xfer_active is 0, pix_clk takes the value of idle_high one cycle later and pix_strobe stays 0.
- R7: pix_strobe is high for one cycle, in the same cycle in which pix_clk shows the launch edge. The launch edge is the rising edge when launch_falling = 0 and the falling edge when launch_falling = 1.
- R8: While clk_en is 0, every register holds its value and every output keeps its level. Counting picks up again from the held state.
- R9: The divider settings are read only on the edge that closes a divider period, and the post-divider setting only at the start of a pixel period. A change that arrives before that edge, including in the cycle just before it, applies to the next period and leaves the current period unchanged.
- R10: While reset is held, pix_clk, pix_strobe and div_tick are all 0. div_tick goes high after the first enabled edge that follows reset, and after that it is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Gating enable; 0 freezes the block |
| xfer_active | input | 1 | A transfer is in progress; 0 puts pix_clk at its idle level |
| div_int | input | N_W | Integer part of the first divider (0 = 2^N_W) |
| div_den | input | FR_W | Fraction denominator |
| div_num | input | FR_W | Fraction numerator |
| post_div | input | PD_W | Post-divide value minus one |
| idle_high | input | 1 | Level of pix_clk when idle |
| launch_falling | input | 1 | 1 = launch on the falling edge, 0 = launch on the rising edge |
| pix_clk | output | 1 | Pixel clock waveform |
| pix_strobe | output | 1 | One-cycle marker of the launch edge |
| div_tick | output | 1 | One-cycle pulse per divider period |

## Verification
Two events can fall in the same cycle. A new setting can arrive in the very cycle before the edge that closes a divider period, so that the latch and the reload coincide. The other case is a pixel period boundary falling inside a running pixel period after its setting has been changed. The bench provokes the first case by changing the integer field one cycle ahead of a known boundary. It then expects the tick spacing to keep the old value once and switch to the new value on the period after. For the second case it changes the post-divider just after a pixel clock rise, and expects one complete period at the old length followed by periods at the new length.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } launch_edge_e;
endpackage

// File: rtl/pcd_frac_stage.sv
module pcd_frac_stage #(
  parameter int N_W  = 8,
  parameter int FR_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [N_W-1:0]  n_fld,
  input  logic [FR_W-1:0] den,
  input  logic [FR_W-1:0] num,
  output logic            tick
);
  localparam int CNT_W = N_W + 1;
  localparam int ACC_W = FR_W + 1;
  localparam logic [CNT_W-1:0] N_FULL = CNT_W'(1) << N_W;
  localparam logic [CNT_W-1:0] N_MIN  = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, n_eff, len_m1;
  logic [ACC_W-1:0] acc_q, acc_sum, acc_nxt;
  logic             frac_on, extra, tick_q;

  // Decode the integer field and decide whether this period is stretched.
  always_comb begin
    if (n_fld == '0)            n_eff = N_FULL;
    else if (n_fld == N_W'(1))  n_eff = N_MIN;
    else                        n_eff = {1'b0, n_fld};
    frac_on = (den != '0) && (num != '0);
    acc_sum = acc_q + {1'b0, num};
    extra   = frac_on && (acc_sum >= {1'b0, den});
    if (!frac_on)   acc_nxt = '0;
    else if (extra) acc_nxt = acc_sum - {1'b0, den};
    else            acc_nxt = acc_sum;
    len_m1  = n_eff - CNT_W'(1) + {{(CNT_W-1){1'b0}}, extra};
  end

  // Settings are sampled only when the count reaches zero (period boundary).
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (en) begin
      if (cnt_q == '0) begin
        cnt_q  <= len_m1;
        acc_q  <= acc_nxt;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - CNT_W'(1);
        tick_q <= 1'b0;
      end
    end
  end

  assign tick = tick_q;

  // R1: a tick never lasts longer than one enabled cycle
  a_r1_tick_single: assert property (@(posedge clk) disable iff (rst)
    (en && tick_q) |=> !tick_q);

  // R8: gating freezes the divider state
  a_r8_gate_freeze: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cnt_q) && $stable(acc_q) && $stable(tick_q)));
endmodule

// File: rtl/pcd_post_stage.sv
module pcd_post_stage #(
  parameter int PD_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic [PD_W-1:0] pd_fld,
  output logic            raw_high
);
  localparam int MW = PD_W + 1;
  localparam logic [MW-1:0] M_MIN = MW'(2);

  logic [PD_W-1:0] pos_q;
  logic [MW-1:0]   m_q, m_in;
  logic            first_q, wrap;

  always_comb begin
    if (pd_fld == '0) m_in = M_MIN;
    else              m_in = {1'b0, pd_fld} + MW'(1);
    wrap     = first_q || ({1'b0, pos_q} == (m_q - MW'(1)));
    raw_high = !first_q && ({1'b0, pos_q} < (m_q >> 1));
  end

  // The post-divide value is taken only when a pixel period begins.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      m_q     <= M_MIN;
      first_q <= 1'b1;
    end else if (en && tick) begin
      if (wrap) begin
        pos_q   <= '0;
        m_q     <= m_in;
        first_q <= 1'b0;
      end else begin
        pos_q   <= pos_q + PD_W'(1);
      end
    end
  end

  // R4: the tick position stays inside the latched pixel period
  a_r4_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    !first_q |-> ({1'b0, pos_q} < m_q));
endmodule

// File: rtl/pcd_out_stage.sv
module pcd_out_stage
  import pcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic xfer,
  input  logic idle_high,
  input  logic launch_fall,
  input  logic raw_high,
  output logic pix_clk,
  output logic pix_strobe
);
  launch_edge_e sel;
  logic raw_d, pix_q, stb_q, edge_hit;

  always_comb begin
    sel = launch_edge_e'(launch_fall);
    case (sel)
      EDGE_FALL: edge_hit = raw_d && !raw_high;
      default:   edge_hit = !raw_d && raw_high;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_d <= 1'b0;
      pix_q <= 1'b0;
      stb_q <= 1'b0;
    end else if (en) begin
      raw_d <= raw_high;
      pix_q <= xfer ? raw_high : idle_high;
      stb_q <= xfer && edge_hit;
    end
  end

  assign pix_clk    = pix_q;
  assign pix_strobe = stb_q;

  // R6: idle level follows the programmed value
  a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
    (en && !xfer) |=> (pix_clk == $past(idle_high)));

  // R6: no launch strobe outside a transfer
  a_r6_quiet_strobe: assert property (@(posedge clk) disable iff (rst)
    (en && !xfer) |=> !pix_strobe);
endmodule

// File: rtl/pixclk_frac_gen.sv
module pixclk_frac_gen #(
  parameter int N_W  = 8,
  parameter int FR_W = 6,
  parameter int PD_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clk_en,
  input  logic            xfer_active,
  input  logic [N_W-1:0]  div_int,
  input  logic [FR_W-1:0] div_den,
  input  logic [FR_W-1:0] div_num,
  input  logic [PD_W-1:0] post_div,
  input  logic            idle_high,
  input  logic            launch_falling,
  output logic            pix_clk,
  output logic            pix_strobe,
  output logic            div_tick
);
  logic tick_w, raw_w;

  pcd_frac_stage #(.N_W(N_W), .FR_W(FR_W)) u_frac (
    .clk   (clk),
    .rst   (rst),
    .en    (clk_en),
    .n_fld (div_int),
    .den   (div_den),
    .num   (div_num),
    .tick  (tick_w)
  );

  pcd_post_stage #(.PD_W(PD_W)) u_post (
    .clk      (clk),
    .rst      (rst),
    .en       (clk_en),
    .tick     (tick_w),
    .pd_fld   (post_div),
    .raw_high (raw_w)
  );

  pcd_out_stage u_out (
    .clk         (clk),
    .rst         (rst),
    .en          (clk_en),
    .xfer        (xfer_active),
    .idle_high   (idle_high),
    .launch_fall (launch_falling),
    .raw_high    (raw_w),
    .pix_clk     (pix_clk),
    .pix_strobe  (pix_strobe)
  );

  assign div_tick = tick_w;
endmodule

// File: tb/pixclk_frac_gen_test.sv
module pixclk_frac_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b1;
  logic       xfer_active = 1'b1;
  logic       idle_high = 1'b0;
  logic       launch_falling = 1'b0;
  logic [7:0] div_int = 8'd3;
  logic [5:0] div_den = '0;
  logic [5:0] div_num = '0;
  logic [5:0] post_div = 6'd1;
  logic       pix_clk, pix_strobe, div_tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pixclk_frac_gen uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .xfer_active(xfer_active),
    .div_int(div_int), .div_den(div_den), .div_num(div_num), .post_div(post_div),
    .idle_high(idle_high), .launch_falling(launch_falling),
    .pix_clk(pix_clk), .pix_strobe(pix_strobe), .div_tick(div_tick)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // n, den, num, K periods, effective N, expected total cycles
  localparam int VEC [0:8][0:5] = '{
    '{  3,  0,  0, 10,   3,  30},
    '{  3,  4,  1,  8,   3,  26},
    '{  5,  3,  2,  6,   5,  34},
    '{  0,  0,  0,  3, 256, 768},
    '{  2, 63, 62, 63,   2, 188},
    '{  7,  5,  0,  5,   7,  35},
    '{  4,  0,  9,  5,   4,  20},
    '{  1,  0,  0,  4,   2,   8},
    '{255,  2,  1,  2, 255, 511}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int n, input int a, input int b, input int p);
    @(negedge clk);
    rst = 1'b1;
    div_int = 8'(n); div_den = 6'(a); div_num = 6'(b); post_div = 6'(p);
    repeat (3) @(negedge clk);
    chk({pix_clk, pix_strobe, div_tick} == 3'b000, "R10 reset outputs",
        int'({pix_clk, pix_strobe, div_tick}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(div_tick == 1'b1, "R10 first tick", int'(div_tick), 1);
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_tick && n < 5000);
  endtask

  task automatic wait_edge(input bit rise, output int n);
    logic prev;
    prev = pix_clk;
    n = 0;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (rise ? (pix_clk && !prev) : (!pix_clk && prev)) break;
      prev = pix_clk;
    end
  endtask

  task automatic pix_meas(input int n, input int p, input int exp_per, input int exp_hi, input string req);
    int d0, h, l;
    do_reset(n, 0, 0, p);
    wait_edge(1'b1, d0);
    chk(d0 == 2, "R5 first rise latency", d0, 2);
    wait_edge(1'b0, h);
    wait_edge(1'b1, l);
    chk(h == exp_hi, {req, " high phase R5"}, h, exp_hi);
    chk(h + l == exp_per, {req, " period R4"}, h + l, exp_per);
  endtask

  task automatic strobe_window(input int len, input bit fall);
    int bad, seen;
    logic prev, want;
    bad = 0; seen = 0;
    prev = pix_clk;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      want = fall ? (prev && !pix_clk) : (!prev && pix_clk);
      if (pix_strobe !== want) bad++;
      if (pix_strobe) seen++;
      prev = pix_clk;
    end
    chk(bad == 0, "R7 strobe alignment", bad, 0);
    chk(seen > 0, "R7 strobe present", seen, 1);
  endtask

  initial begin
    int t, cnt, last, iv, bad, n;
    // Table walk: R1, R2, R3
    for (int i = 0; i < 9; i++) begin
      xfer_active = 1'b1; clk_en = 1'b1;
      do_reset(VEC[i][0], VEC[i][1], VEC[i][2], 1);
      t = 0; cnt = 0; last = 0; bad = 0;
      while (cnt < VEC[i][3] && t < 5000) begin
        @(negedge clk);
        t++;
        if (div_tick) begin
          iv = t - last;
          last = t;
          cnt++;
          if (!(iv == VEC[i][4] ||
                ((VEC[i][1] != 0 && VEC[i][2] != 0) && iv == VEC[i][4] + 1))) bad++;
        end
      end
      chk(t == VEC[i][5], $sformatf("R1 R2 R3 vector %0d total", i), t, VEC[i][5]);
      chk(bad == 0, $sformatf("R1 R3 vector %0d period set", i), bad, 0);
    end

    // R4 / R5 post-divider shapes
    pix_meas(3, 4, 15, 6, "M5");
    pix_meas(3, 0, 6, 3, "M2 from field 0");
    pix_meas(2, 63, 128, 64, "M64");

    // R7 launch edge select
    launch_falling = 1'b0;
    do_reset(3, 0, 0, 2);
    strobe_window(60, 1'b0);
    launch_falling = 1'b1;
    do_reset(3, 0, 0, 2);
    strobe_window(60, 1'b1);
    launch_falling = 1'b0;

    // R6 idle levels
    do_reset(2, 0, 0, 1);
    xfer_active = 1'b0; idle_high = 1'b1;
    repeat (2) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pix_clk !== 1'b1 || pix_strobe !== 1'b0) bad++;
    end
    chk(bad == 0, "R6 idle high", bad, 0);
    idle_high = 1'b0;
    repeat (2) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pix_clk !== 1'b0 || pix_strobe !== 1'b0) bad++;
    end
    chk(bad == 0, "R6 idle low", bad, 0);
    xfer_active = 1'b1;

    // R8 gating: freeze, then resume from held count
    do_reset(3, 0, 0, 0);
    clk_en = 1'b0;
    begin
      logic hp, hs, ht;
      hp = pix_clk; hs = pix_strobe; ht = div_tick;
      bad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (pix_clk !== hp || pix_strobe !== hs || div_tick !== ht) bad++;
      end
    end
    chk(bad == 0, "R8 outputs held", bad, 0);
    clk_en = 1'b1;
    wait_tick(n);
    chk(20 + n == 23, "R8 resume interval", 20 + n, 23);

    // R9 late change of the integer part, one cycle before the boundary
    do_reset(10, 0, 0, 1);
    repeat (9) @(negedge clk);
    div_int = 8'd4;
    @(negedge clk);
    chk(div_tick == 1'b1, "R9 running period kept", int'(div_tick), 1);
    wait_tick(n);
    chk(n == 4, "R9 new period applied", n, 4);

    // R9 post-divider change inside a pixel period
    begin
      int d0, h, l, h2, l2;
      do_reset(2, 0, 0, 3);
      wait_edge(1'b1, d0);
      post_div = 6'd1;
      wait_edge(1'b0, h);
      wait_edge(1'b1, l);
      chk(h + l == 8, "R9 pixel period kept", h + l, 8);
      chk(h == 4, "R9 pixel high kept", h, 4);
      wait_edge(1'b0, h2);
      wait_edge(1'b1, l2);
      chk(h2 + l2 == 4, "R9 pixel period applied", h2 + l2, 4);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule